// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Condition-Code Register

This block is the single-cycle datapath of a small processor. It takes a first operand, a second operand picked from either a register value or an already extended immediate, and a 5-bit operation code. It produces the result in the same cycle. The operations are add, subtract, low-half multiply, the three bitwise logic functions, compare, fixed-distance logical shifts, single-bit rotates, a sign-keeping right shift and a byte-order reversal.

A 5-bit condition-code register sits beside the datapath. When the flag-write input is high, it captures zero, equals-one, carry, signed less-than and signed greater-than at the clock edge. Branch logic uses this register, together with two derived outputs for "not zero" and "carry clear". Compare updates only the flags. It drives a zero result with the destination write strobe low, so the register file keeps its contents.

Clearing a destination register is done by adding two zero operands. The result is zero and the zero flag is set.

Top module: `alu_cc_unit`

## Requirements
- R1: Add (code 0) outputs a+b modulo 2^W. Carry (ccr bit 2) is the carry out of bit W-1. 0+0 gives a zero result and sets the zero flag (ccr bit 0).
- R2: For every two-operand code, sel_imm=1 selects opnd_b_imm as the second operand and sel_imm=0 selects opnd_b_reg. The unselected input has no effect on the result.
- R3: Subtract (code 1) outputs a-b. Carry means a borrow occurred (a<b unsigned). Less-than (bit 3) and greater-than (bit 4) come from a signed comparison of a against b. Zero is set when a equals b, and equals-one (bit 1) when a-b is 1.
- R4: Multiply (code 2) outputs the low W bits of a*b and clears carry.
- R5: Compare (code 6) sets the flags exactly as subtract would. It drives result 0 and dest_we 0.
- R6: OR (3), AND (4) and XOR (5) are bitwise and clear carry.
- R7: Logical shifts fill with zeros: left by 1 (7), left by 8 (8), right by 1 (9), right by 8 (10). Carry holds the bit shifted out for the 1-bit forms and is 0 for the 8-bit forms.
- R8: Rotate left by 1 (11) and rotate right by 1 (12) wrap the end bit around. Carry holds the wrapped bit.
- R9: Arithmetic right shift (13) moves right one bit, keeps the most significant bit, and puts bit 0 in carry.
- R10: Byte swap (14) moves byte k to byte W/8-1-k and clears carry.
- R11: For all codes other than subtract and compare, less-than is the result's top bit, and greater-than is set for a nonzero result with a clear top bit. The flags are written at the clock edge when flag_we=1. When flag_we=0 they hold.
- R12: flag_nz is the inverse of the zero flag and flag_nc is the inverse of carry.
- R13: Codes 15 to 31 drive result 0 and dest_we 0, and leave ccr unchanged even when flag_we=1. dest_we is 1 for every other code except compare.
- R14: After reset, ccr is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| opnd_a | input | W | First operand |
| opnd_b_reg | input | W | Second operand from register |
| opnd_b_imm | input | W | Second operand from immediate |
| sel_imm | input | 1 | Select immediate as second operand |
| op_code | input | 5 | Operation code |
| flag_we | input | 1 | Capture flags at this clock edge |
| result | output | W | Combinational result |
| dest_we | output | 1 | Result is to be written back |
| ccr | output | 5 | Flags: [0] zero, [1] one, [2] carry, [3] less, [4] greater |
| flag_nz | output | 1 | Not-zero condition |
| flag_nc | output | 1 | Carry-clear condition |

## Verification
The assertions rely on the inputs being stable and known at each rising edge, because the flag register samples the combinational result there. They also rely on op_code being a defined 5-bit value. The bench drives every input at the falling edge and holds it through the next rising edge. It sweeps all codes, including the unassigned ones, across a table of boundary operand values on a 16-bit instance. Immediate and register operands alternate, and the unselected operand always carries a different value.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_SUB   = 5'd1,
    OP_MUL   = 5'd2,
    OP_OR    = 5'd3,
    OP_AND   = 5'd4,
    OP_XOR   = 5'd5,
    OP_CMP   = 5'd6,
    OP_SHL1  = 5'd7,
    OP_SHL8  = 5'd8,
    OP_SHR1  = 5'd9,
    OP_SHR8  = 5'd10,
    OP_ROL1  = 5'd11,
    OP_ROR1  = 5'd12,
    OP_ASR1  = 5'd13,
    OP_BSWAP = 5'd14
  } alu_op_e;

  localparam int FLG_Z   = 0;
  localparam int FLG_ONE = 1;
  localparam int FLG_C   = 2;
  localparam int FLG_LT  = 3;
  localparam int FLG_GT  = 4;
  localparam int FLG_W   = 5;

  function automatic logic code_defined(input logic [4:0] code);
    return code <= 5'd14;
  endfunction

  function automatic logic code_is_subtract(input logic [4:0] code);
    return (code == 5'd1) || (code == 5'd6);
  endfunction

endpackage

// File: rtl/alu_cc_arith.sv
module alu_cc_arith
  import alu_cc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] arith_res,
  output logic [W-1:0] diff,
  output logic         arith_carry,
  output logic         sgn_lt,
  output logic         sgn_gt
);

  localparam int EXT = W + 1;

  function automatic logic [EXT-1:0] add_ext(input logic [W-1:0] x, input logic [W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  function automatic logic [EXT-1:0] sub_ext(input logic [W-1:0] x, input logic [W-1:0] y);
    return {1'b0, x} - {1'b0, y};
  endfunction

  function automatic logic [W-1:0] mul_low(input logic [W-1:0] x, input logic [W-1:0] y);
    return x * y;
  endfunction

  logic [EXT-1:0] sum_w;
  logic [EXT-1:0] dif_w;
  logic [W-1:0]   prod_w;
  logic           borrow;
  logic           sub_ovf;

  assign sum_w  = add_ext(a, b);
  assign dif_w  = sub_ext(a, b);
  assign prod_w = mul_low(a, b);
  assign borrow = dif_w[W];
  assign diff   = dif_w[W-1:0];

  // signed order from the difference sign corrected by overflow
  assign sub_ovf = (a[W-1] != b[W-1]) && (dif_w[W-1] != a[W-1]);
  assign sgn_lt  = dif_w[W-1] ^ sub_ovf;
  assign sgn_gt  = !sgn_lt && (diff != '0);

  always_comb begin
    arith_res   = '0;
    arith_carry = 1'b0;
    unique case (op)
      OP_ADD: begin
        arith_res   = sum_w[W-1:0];
        arith_carry = sum_w[W];
      end
      OP_SUB, OP_CMP: begin
        arith_res   = diff;
        arith_carry = borrow;
      end
      OP_MUL: begin
        arith_res   = prod_w;
        arith_carry = 1'b0;
      end
      default: begin
        arith_res   = '0;
        arith_carry = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/alu_cc_bitops.sv
module alu_cc_bitops
  import alu_cc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] bit_res,
  output logic         bit_carry
);

  localparam int NB = W / 8;

  logic [W-1:0] swapped;

  genvar k;
  generate
    for (k = 0; k < NB; k++) begin : g_byte
      assign swapped[8*k +: 8] = a[8*(NB-1-k) +: 8];
    end
  endgenerate

  function automatic logic [W-1:0] shl_n(input logic [W-1:0] x, input int n);
    return x << n;
  endfunction

  function automatic logic [W-1:0] shr_n(input logic [W-1:0] x, input int n);
    return x >> n;
  endfunction

  always_comb begin
    bit_res   = '0;
    bit_carry = 1'b0;
    unique case (op)
      OP_OR:    bit_res = a | b;
      OP_AND:   bit_res = a & b;
      OP_XOR:   bit_res = a ^ b;
      OP_SHL1: begin
        bit_res   = shl_n(a, 1);
        bit_carry = a[W-1];
      end
      OP_SHL8:  bit_res = shl_n(a, 8);
      OP_SHR1: begin
        bit_res   = shr_n(a, 1);
        bit_carry = a[0];
      end
      OP_SHR8:  bit_res = shr_n(a, 8);
      OP_ROL1: begin
        bit_res   = {a[W-2:0], a[W-1]};
        bit_carry = a[W-1];
      end
      OP_ROR1: begin
        bit_res   = {a[0], a[W-1:1]};
        bit_carry = a[0];
      end
      OP_ASR1: begin
        bit_res   = {a[W-1], a[W-1:1]};
        bit_carry = a[0];
      end
      OP_BSWAP: bit_res = swapped;
      default: begin
        bit_res   = '0;
        bit_carry = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/alu_cc_flags.sv
module alu_cc_flags
  import alu_cc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic             cmp_mode,
  input  logic             cmp_lt,
  input  logic             cmp_gt,
  input  logic             carry_in,
  input  logic [W-1:0]     flag_val,
  output logic [FLG_W-1:0] ccr
);

  logic [FLG_W-1:0] ccr_next;
  logic             val_zero;

  assign val_zero = (flag_val == '0);

  always_comb begin
    ccr_next          = '0;
    ccr_next[FLG_Z]   = val_zero;
    ccr_next[FLG_ONE] = (flag_val == W'(1));
    ccr_next[FLG_C]   = carry_in;
    ccr_next[FLG_LT]  = cmp_mode ? cmp_lt : flag_val[W-1];
    ccr_next[FLG_GT]  = cmp_mode ? cmp_gt : (!flag_val[W-1] && !val_zero);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ccr <= '0;
    else if (upd) ccr <= ccr_next;
  end

  // R11: flags hold when no update is requested
  p_flags_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(ccr));

  // R11: the zero flag follows the value presented at the update edge
  p_zero_tracks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (ccr[FLG_Z] == ($past(flag_val) == '0)));

  // R3: a zero outcome excludes both order flags
  p_zero_no_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ccr[FLG_Z] |-> !(ccr[FLG_LT] || ccr[FLG_GT]));

endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
  import alu_cc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b_reg,
  input  logic [DATA_W-1:0] opnd_b_imm,
  input  logic              sel_imm,
  input  logic [4:0]        op_code,
  input  logic              flag_we,
  output logic [DATA_W-1:0] result,
  output logic              dest_we,
  output logic [4:0]        ccr,
  output logic              flag_nz,
  output logic              flag_nc
);

  alu_op_e           op;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] arith_res;
  logic [DATA_W-1:0] diff;
  logic              arith_carry;
  logic              sgn_lt;
  logic              sgn_gt;
  logic [DATA_W-1:0] bit_res;
  logic              bit_carry;
  logic              is_arith;
  logic              defined;
  logic              is_cmp;
  logic [DATA_W-1:0] flag_val;
  logic              flag_carry;
  logic              flag_upd;

  assign op      = alu_op_e'(op_code);
  assign opnd_b  = sel_imm ? opnd_b_imm : opnd_b_reg;
  assign defined = code_defined(op_code);
  assign is_cmp  = (op == OP_CMP);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL) || is_cmp;

  alu_cc_arith #(.W(DATA_W)) u_arith (
    .a           (opnd_a),
    .b           (opnd_b),
    .op          (op),
    .arith_res   (arith_res),
    .diff        (diff),
    .arith_carry (arith_carry),
    .sgn_lt      (sgn_lt),
    .sgn_gt      (sgn_gt)
  );

  alu_cc_bitops #(.W(DATA_W)) u_bits (
    .a         (opnd_a),
    .b         (opnd_b),
    .op        (op),
    .bit_res   (bit_res),
    .bit_carry (bit_carry)
  );

  always_comb begin
    if (!defined) begin
      flag_val   = '0;
      flag_carry = 1'b0;
    end else if (is_arith) begin
      flag_val   = arith_res;
      flag_carry = arith_carry;
    end else begin
      flag_val   = bit_res;
      flag_carry = bit_carry;
    end
  end

  assign result   = (defined && !is_cmp) ? flag_val : '0;
  assign dest_we  = defined && !is_cmp;
  assign flag_upd = flag_we && defined;

  alu_cc_flags #(.W(DATA_W)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (flag_upd),
    .cmp_mode (code_is_subtract(op_code)),
    .cmp_lt   (sgn_lt),
    .cmp_gt   (sgn_gt),
    .carry_in (flag_carry),
    .flag_val (flag_val),
    .ccr      (ccr)
  );

  assign flag_nz = !ccr[FLG_Z];
  assign flag_nc = !ccr[FLG_C];

  // R5: compare never produces a write-back
  p_cmp_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 5'd6) |-> (!dest_we && result == '0));

  // R13: undefined codes are inert
  p_undef_inert_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code > 5'd14) |=> $stable(ccr));

  // R4: multiply leaves carry clear
  p_mul_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op_code == 5'd2) |=> !ccr[FLG_C]);

  // R3: borrow tracks unsigned order of the operands
  p_borrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op_code == 5'd1) |=> (ccr[FLG_C] == ($past(opnd_a) < $past(opnd_b))));

endmodule

// File: tb/alu_cc_unit_test.sv
module alu_cc_unit_test;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b_reg = '0;
  logic [W-1:0] opnd_b_imm = '0;
  logic         sel_imm = 1'b0;
  logic [4:0]   op_code = '0;
  logic         flag_we = 1'b0;
  logic [W-1:0] result;
  logic         dest_we;
  logic [4:0]   ccr;
  logic         flag_nz;
  logic         flag_nc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [4:0] exp_ccr = '0;

  always #2 clk = ~clk;

  alu_cc_unit #(.DATA_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b_reg(opnd_b_reg),
    .opnd_b_imm(opnd_b_imm), .sel_imm(sel_imm), .op_code(op_code),
    .flag_we(flag_we), .result(result), .dest_we(dest_we), .ccr(ccr),
    .flag_nz(flag_nz), .flag_nc(flag_nc)
  );

  function automatic logic [W-1:0] pick(input int k);
    case (k)
      0: return 16'h0000;  1: return 16'h0001;  2: return 16'h0002;  3: return 16'h7FFF;
      4: return 16'h8000;  5: return 16'h8001;  6: return 16'hFFFF;  7: return 16'hFFFE;
      8: return 16'h00FF;  9: return 16'hFF00; 10: return 16'h1234; 11: return 16'hA5C3;
      12: return 16'h0100; 13: return 16'h7F80; 14: return 16'h5555; default: return 16'hAAAA;
    endcase
  endfunction

  task automatic model(input int op, input logic [W-1:0] a, input logic [W-1:0] b,
                       output logic [W-1:0] r, output logic we, output logic [4:0] f,
                       output logic ok);
    longint ua = a;
    longint ub = b;
    longint t;
    logic [W-1:0] fv;
    logic c = 1'b0;
    logic sub = 1'b0;
    ok = 1'b1;
    case (op)
      0: begin t = ua + ub; fv = W'(t % 65536); c = (t > 65535); end
      1, 6: begin t = (ua - ub + 65536) % 65536; fv = W'(t); c = (ua < ub); sub = 1'b1; end
      2: begin t = (ua * ub) % 65536; fv = W'(t); end
      3: fv = a | b;
      4: fv = a & b;
      5: fv = a ^ b;
      7: begin fv = W'((ua * 2) % 65536); c = (ua >= 32768); end
      8: fv = W'((ua * 256) % 65536);
      9: begin fv = W'(ua / 2); c = ua[0]; end
      10: fv = W'(ua / 256);
      11: begin fv = W'((ua * 2) % 65536 + ua / 32768); c = (ua >= 32768); end
      12: begin fv = W'(ua / 2 + (ua % 2) * 32768); c = ua[0]; end
      13: begin fv = W'(ua / 2 + ((ua >= 32768) ? 32768 : 0)); c = ua[0]; end
      14: fv = W'((ua % 256) * 256 + ua / 256);
      default: begin fv = '0; ok = 1'b0; end
    endcase
    f = '0;
    f[0] = (fv == 0);
    f[1] = (fv == 1);
    f[2] = c;
    if (sub) begin
      f[3] = ($signed(a) < $signed(b));
      f[4] = ($signed(a) > $signed(b));
    end else begin
      f[3] = fv[W-1];
      f[4] = !fv[W-1] && (fv != 0);
    end
    we = ok && (op != 6);
    r  = we ? fv : '0;
  endtask

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input int op);
    case (op)
      0: return "R1"; 1: return "R3"; 2: return "R4"; 3, 4, 5: return "R6"; 6: return "R5";
      7, 8, 9, 10: return "R7"; 11, 12: return "R8"; 13: return "R9"; 14: return "R10";
      default: return "R13";
    endcase
  endfunction

  task automatic apply(input int op, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic imm, input logic fwe);
    logic [W-1:0] r;
    logic we;
    logic [4:0] f;
    logic ok;
    model(op, a, b, r, we, f, ok);
    @(negedge clk);
    op_code = 5'(op);
    opnd_a = a;
    sel_imm = imm;
    flag_we = fwe;
    if (imm) begin opnd_b_imm = b; opnd_b_reg = ~b ^ 16'h3C3C; end
    else     begin opnd_b_reg = b; opnd_b_imm = ~b ^ 16'hC3C3; end
    #1;
    check(imm ? "R2" : req_of(op), "result", result, r);
    check(req_of(op), "dest_we", dest_we, we);
    @(posedge clk);
    #1;
    if (fwe && ok) exp_ccr = f;
    check(fwe ? (ok ? req_of(op) : "R13") : "R11", "ccr", ccr, exp_ccr);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R14 reset state and R12 derived conditions
    check("R14", "ccr", ccr, 0);
    check("R12", "flag_nz", flag_nz, 1);
    check("R12", "flag_nc", flag_nc, 1);
    @(negedge clk);
    rst_n = 1'b1;

    // sweep of all defined codes (R1..R11)
    for (int op = 0; op < 15; op++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++) begin
          apply(op, pick(i), pick(j), 1'((i + j + op) % 2), 1'b1);
          check("R12", "flag_nz", flag_nz, !exp_ccr[0]);
          check("R12", "flag_nc", flag_nc, !exp_ccr[2]);
        end

    // R1: clearing via 0+0
    apply(0, 16'h0000, 16'h0000, 1'b0, 1'b1);
    check("R1", "zero flag", ccr[0], 1);

    // R11: flags hold with flag_we low across varied ops
    apply(1, 16'h0003, 16'h0005, 1'b0, 1'b1);
    for (int op = 0; op < 15; op++) apply(op, pick(op), pick(15 - op), 1'b0, 1'b0);

    // R13: undefined codes with flag_we high
    for (int op = 15; op < 32; op++) apply(op, pick(op % 16), pick(3), 1'(op % 2), 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule